// File: doc/BRIEF.md
# Shadow-Copy Register Bank with Live Override

This block is a bank of bus-mapped I/O registers. Its read path does not come from a multiplexer across every register. A bus slave port with address, write data, write strobe and read strobe drives it. A write that lands in the bank's address window does two things. It updates the matching real output register, if there is one at that offset. It also stores the same value in a synchronous shadow RAM at the same offset.

Reads are served from the shadow RAM, so the readback logic is a single narrow selector and not a wide tree. A few offsets can be claimed by peripherals that need their live state to be visible. When such a peripheral raises its override enable, a read of its offset returns the peripheral's live value instead of the stored copy.

The window holds `DEPTH` words. Only the lowest `NUM_REGS` offsets drive real output pins. The offsets above them are shadow-only storage. Read data appears exactly one cycle after the read strobe.

Top module: `shadow_regbank`

## Requirements
- R1: A write with the address at window offset i, where i < NUM_REGS, sets output register i to the write data on the next cycle. At most one output register is written per cycle. Register i occupies `reg_out[i*DATA_W +: DATA_W]`.
- R2: Every write inside the window stores its data at the same offset in the shadow RAM. A later read of that offset, with no override active, returns the stored value.
- R3: A write to a window offset of NUM_REGS or above changes no output register. It is still stored and read back as in R2.
- R4: A read of override offset `OVR_OFS[k*16 +: 16]` while `ovr_en[k]` is high in the strobe cycle returns `ovr_val[k*DATA_W +: DATA_W]` as sampled in that cycle. A read of that offset while `ovr_en[k]` is low returns the shadow copy. A raised `ovr_en[k]` has no effect on reads of other offsets.
- R5: `rd_data` carries the result in the cycle after `rd_en`. In any cycle not preceded by a read strobe, `rd_data` is zero.
- R6: A write and a read to the same address in one cycle return the value held before the write. The next read of that address returns the new value.
- R7: A write to an address outside [WIN_BASE, WIN_BASE+DEPTH) changes no output register and no shadow entry. This includes an address that would alias onto a window offset if truncated.
- R8: A read of an address outside the window returns zero.
- R9: After reset, every output register is zero and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Bus address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid the cycle after `rd_en` |
| reg_out | output | NUM_REGS*DATA_W | Real register outputs, register i at slice i |
| ovr_en | input | NUM_OVR | Per-peripheral live-value override request |
| ovr_val | input | NUM_OVR*DATA_W | Per-peripheral live values, source k at slice k |

## Verification
The bench builds the bank with a 12-bit address, a 64-word window based at 0x100, four real registers, and two override sources at offsets 2 and 5. Offset 2 places an override on a real register and offset 5 places one on a shadow-only word. The small window lets the bench fill every shadow entry first and then reach each entry many times under random traffic. Addresses 0x0FF, 0x140 and 0x143 sit just outside both edges of the window. 0x143 aliases offset 3 under truncation, so writes to it expose a missing window check.

// File: rtl/shadow_regbank_pkg.sv
package shadow_regbank_pkg;

  // Width of each override offset field in the OVR_OFS parameter.
  localparam int unsigned OFS_W = 16;

  // True when address a falls inside [base, base+depth).
  function automatic logic win_hit(input logic [31:0] a,
                                   input logic [31:0] base,
                                   input logic [31:0] depth);
    return (a >= base) && ((a - base) < depth);
  endfunction

  // Offset of address a from the window base (meaningful only on a hit).
  function automatic logic [31:0] win_offset(input logic [31:0] a,
                                             input logic [31:0] base);
    return a - base;
  endfunction

endpackage

// File: rtl/shadow_regbank_decode.sv
module shadow_regbank_decode
  import shadow_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DEPTH    = 512,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned NUM_OVR  = 2,
  parameter logic [NUM_OVR*OFS_W-1:0] OVR_OFS = '0,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_OVR-1:0]  ovr_en,
  output logic                in_win,
  output logic [IDX_W-1:0]    idx,
  output logic                shadow_we,
  output logic [NUM_REGS-1:0] reg_we,
  output logic [NUM_OVR-1:0]  ovr_hit
);

  logic [31:0] ofs;

  always_comb begin
    in_win    = win_hit(32'(addr), 32'(WIN_BASE), 32'(DEPTH));
    ofs       = win_offset(32'(addr), 32'(WIN_BASE));
    idx       = ofs[IDX_W-1:0];
    shadow_we = wr_en & in_win;
  end

  // One write enable per real register.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_dec
    assign reg_we[i] = wr_en & in_win & (ofs == 32'(i));
  end

  // Override hit: a read of the claimed offset while the source asks for it.
  for (genvar k = 0; k < NUM_OVR; k++) begin : g_ovr_dec
    assign ovr_hit[k] = rd_en & in_win & ovr_en[k] &
                        (ofs == 32'(OVR_OFS[k*OFS_W +: OFS_W]));
  end

endmodule

// File: rtl/shadow_regbank_ram.sv
module shadow_regbank_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Synchronous read of the pre-write contents (read-before-write).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/shadow_regbank_rdmux.sv
module shadow_regbank_rdmux #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_OVR = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic                      in_win,
  input  logic [NUM_OVR-1:0]        ovr_hit,
  input  logic [NUM_OVR*DATA_W-1:0] ovr_val,
  input  logic [DATA_W-1:0]         ram_q,
  output logic [DATA_W-1:0]         rd_data
);

  logic              rd_q, win_q, hit_q;
  logic [DATA_W-1:0] live_sel, live_q;

  // Pick the live value of whichever source hit (offsets are distinct).
  always_comb begin
    live_sel = '0;
    for (int k = 0; k < NUM_OVR; k++)
      if (ovr_hit[k]) live_sel = ovr_val[k*DATA_W +: DATA_W];
  end

  // Stage the select alongside the RAM read so both land in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      win_q  <= 1'b0;
      hit_q  <= 1'b0;
      live_q <= '0;
    end else begin
      rd_q   <= rd_en;
      win_q  <= in_win;
      hit_q  <= |ovr_hit;
      live_q <= live_sel;
    end
  end

  always_comb begin
    if (!rd_q || !win_q) rd_data = '0;
    else if (hit_q)      rd_data = live_q;
    else                 rd_data = ram_q;
  end

endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank
  import shadow_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 512,
  parameter logic [ADDR_W-1:0] WIN_BASE = 12'h200,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned NUM_OVR  = 2,
  parameter logic [NUM_OVR*OFS_W-1:0] OVR_OFS = {16'd9, 16'd3}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] reg_out,
  input  logic [NUM_OVR-1:0]         ovr_en,
  input  logic [NUM_OVR*DATA_W-1:0]  ovr_val
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  // Named internal events, also watched by the checker.
  logic                in_win;
  logic [IDX_W-1:0]    idx;
  logic                shadow_we;
  logic [NUM_REGS-1:0] reg_we;
  logic [NUM_OVR-1:0]  ovr_hit;
  logic [DATA_W-1:0]   ram_q;

  shadow_regbank_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WIN_BASE(WIN_BASE),
    .NUM_REGS(NUM_REGS), .NUM_OVR(NUM_OVR), .OVR_OFS(OVR_OFS)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .ovr_en(ovr_en),
    .in_win(in_win), .idx(idx), .shadow_we(shadow_we),
    .reg_we(reg_we), .ovr_hit(ovr_hit)
  );

  // Real output registers.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)         q <= '0;
      else if (reg_we[i]) q <= wr_data;
    end
    assign reg_out[i*DATA_W +: DATA_W] = q;
  end

  shadow_regbank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(shadow_we), .waddr(idx), .wdata(wr_data),
    .re(rd_en & in_win), .raddr(idx), .rdata(ram_q)
  );

  shadow_regbank_rdmux #(.DATA_W(DATA_W), .NUM_OVR(NUM_OVR)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .in_win(in_win),
    .ovr_hit(ovr_hit), .ovr_val(ovr_val), .ram_q(ram_q), .rd_data(rd_data)
  );

endmodule

// File: rtl/shadow_regbank_chk.sv
module shadow_regbank_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned NUM_OVR  = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          wr_data,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_REGS*DATA_W-1:0] reg_out,
  input logic [NUM_OVR*DATA_W-1:0]  ovr_val,
  input logic                       in_win,
  input logic [NUM_REGS-1:0]        reg_we,
  input logic [NUM_OVR-1:0]         ovr_hit
);

  // R1
  reg_we_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg_chk
    // R1
    reg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we[i] |=> reg_out[i*DATA_W +: DATA_W] == $past(wr_data));
  end

  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|reg_we) |=> $stable(reg_out));

  for (genvar k = 0; k < NUM_OVR; k++) begin : g_ovr_chk
    // R4
    live_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_hit[k] |=> rd_data == $past(ovr_val[k*DATA_W +: DATA_W]));
  end

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);

  // R7
  outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_win) |=> $stable(reg_out));

  // R8
  outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_win) |=> rd_data == '0);

endmodule

bind shadow_regbank shadow_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_OVR(NUM_OVR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .reg_out(reg_out), .ovr_val(ovr_val),
  .in_win(in_win), .reg_we(reg_we), .ovr_hit(ovr_hit)
);

// File: tb/shadow_regbank_tb.sv
module shadow_regbank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int NREG = 4;
  localparam int NOVR = 2;
  localparam logic [AW-1:0] BASE = 12'h100;
  localparam int OFS0 = 2;
  localparam int OFS1 = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NREG*DW-1:0] reg_out;
  logic [NOVR-1:0] ovr_en = '0;
  logic [NOVR*DW-1:0] ovr_val = '0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [DW-1:0] sh_m [DEPTH];
  logic [DW-1:0] reg_m [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_regbank #(
    .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .WIN_BASE(BASE),
    .NUM_REGS(NREG), .NUM_OVR(NOVR), .OVR_OFS({16'(OFS1), 16'(OFS0)})
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .reg_out(reg_out),
    .ovr_en(ovr_en), .ovr_val(ovr_val)
  );

  function automatic bit inside_win(logic [AW-1:0] a);
    return (int'(a) >= int'(BASE)) && (int'(a) < int'(BASE) + DEPTH);
  endfunction

  function automatic logic [DW-1:0] expect_read(logic [AW-1:0] a,
                                                logic [NOVR-1:0] oe,
                                                logic [NOVR*DW-1:0] ov);
    int o;
    if (!inside_win(a)) return '0;
    o = int'(a) - int'(BASE);
    if (oe[0] && o == OFS0) return ov[DW-1:0];
    if (oe[1] && o == OFS1) return ov[2*DW-1:DW];
    return sh_m[o];
  endfunction

  function automatic logic [NREG*DW-1:0] packed_regs();
    logic [NREG*DW-1:0] r;
    for (int i = 0; i < NREG; i++) r[i*DW +: DW] = reg_m[i];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [NREG*DW-1:0] act,
                       logic [NREG*DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // Drive one bus cycle from a negedge; check results at the next negedge.
  task automatic step(bit we, bit re, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic [NOVR-1:0] oe, logic [NOVR*DW-1:0] ov, string tag);
    logic [DW-1:0] exp_rd;
    wr_en = we; rd_en = re; addr = a; wr_data = d; ovr_en = oe; ovr_val = ov;
    exp_rd = re ? expect_read(a, oe, ov) : '0;   // old contents: read-before-write
    if (we && inside_win(a)) begin
      int o = int'(a) - int'(BASE);
      sh_m[o] = d;
      if (o < NREG) reg_m[o] = d;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(tag, "rd_data", {{(NREG-1)*DW{1'b0}}, rd_data},
          {{(NREG-1)*DW{1'b0}}, exp_rd});
    check(tag, "reg_out", reg_out, packed_regs());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) reg_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", "reg_out", reg_out, '0);
    check("R9", "rd_data", {{(NREG-1)*DW{1'b0}}, rd_data}, '0);

    // R2 fill every shadow entry, then read each back
    for (int i = 0; i < DEPTH; i++)
      step(1, 0, BASE + AW'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), '0, '0, "R2");
    for (int i = 0; i < DEPTH; i++)
      step(0, 1, BASE + AW'(i), '0, '0, '0, "R2");

    // R1 real register update
    step(1, 0, BASE + 12'd1, 32'hDEADBEEF, '0, '0, "R1");
    step(1, 0, BASE + 12'd3, 32'h12345678, '0, '0, "R1");
    // R3 shadow-only offset
    step(1, 0, BASE + 12'd40, 32'hCAFEF00D, '0, '0, "R3");
    step(0, 1, BASE + 12'd40, '0, '0, '0, "R3");
    // R6 same-cycle write and read
    step(1, 1, BASE + 12'd3, 32'h0BADF00D, '0, '0, "R6");
    step(0, 1, BASE + 12'd3, '0, '0, '0, "R6");
    // R4 overrides
    step(0, 1, BASE + 12'd2, '0, 2'b01, {32'h1111_2222, 32'h3333_4444}, "R4");
    step(0, 1, BASE + 12'd2, '0, 2'b00, {32'h1111_2222, 32'h3333_4444}, "R4");
    step(0, 1, BASE + 12'd5, '0, 2'b10, {32'h5555_6666, 32'h7777_8888}, "R4");
    step(0, 1, BASE + 12'd1, '0, 2'b11, {32'h5555_6666, 32'h7777_8888}, "R4");
    // R7 outside writes, including aliasing address 0x143
    step(1, 0, 12'h143, 32'hFFFF0000, '0, '0, "R7");
    step(1, 0, 12'h0FF, 32'hFFFF0001, '0, '0, "R7");
    step(0, 1, BASE + 12'd3, '0, '0, '0, "R7");
    // R8 outside reads
    step(0, 1, 12'h0FF, '0, '0, '0, "R8");
    step(0, 1, 12'h140, '0, '0, '0, "R8");
    step(0, 1, 12'hFFF, '0, '0, '0, "R8");
    // R5 idle cycle after a read
    step(0, 1, BASE + 12'd7, '0, '0, '0, "R5");
    step(0, 0, BASE + 12'd7, '0, '0, '0, "R5");

    // Random traffic: R2 R4 R5 R6 R7 R8
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      if ($urandom_range(9) < 7) a = BASE + AW'($urandom_range(DEPTH-1));
      else                       a = AW'($urandom);
      step(1'($urandom), 1'($urandom), a, $urandom, 2'($urandom),
           {$urandom, $urandom}, "R2-random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule